// File: doc/BRIEF.md
# Synchronous SYN Character Aligner

This block sits behind a bit-clock recovery stage in a receiver for synchronous, unframed serial data. Each recovered bit arrives with a one-cycle strobe. Characters are 8 bits wide and carry no start or stop bits, so the aligner has to find where each character begins. It does this with the idle character, SYN, which the sender transmits repeatedly before any data and whenever it has nothing else to send.

While hunting, the aligner keeps a sliding 8-bit window over the stream and compares it with the SYN code after every new bit. Each mismatch therefore acts as a slip of one bit position. A first match fixes a candidate boundary. Lock is declared only after a set number of SYN characters in a row at that same boundary. Once locked, every 8-bit group is delivered as an aligned character with a strobe, and a received SYN is flagged on its own output rather than passed on as data.

Each delivered character is checked for odd parity. After a set number of consecutive parity failures, lock is dropped and the hunt starts again. The SYN code, the bit order within a character, the lock count and the failure count are all parameters.

Top module: `syn_aligner`

## Requirements
- R1: After reset, `locked_o`, `char_vld_o`, `syn_o` and `par_err_o` are all low.
- R2: While not locked, neither `char_vld_o` nor `syn_o` is ever raised, whatever bits arrive.
- R3: Alignment is found at any bit offset: a SYN whose first bit arrives at a position that is not a multiple of 8 after reset is still recognised.
- R4: Lock (`locked_o` high) requires LOCK_N SYN characters (default 2) at one alignment with nothing between them. A SYN followed by a non-SYN character at that alignment returns to hunting and does not lock.
- R5: While locked, the strobe that completes each 8-bit group is followed one clock later by exactly one single-cycle pulse. With the default MSB-first order, the first bit received lands in `char_o[7]`.
- R6: A SYN code (default 8'h16) received while locked raises `syn_o` and not `char_vld_o`.
- R7: `par_err_o` is high together with `char_vld_o` when the character holds an even number of ones. Odd parity is required, and SYN 8'h16 passes.
- R8: After BAD_N consecutive characters with a parity failure (default 3), lock is dropped. A character with good parity, or a SYN, resets the run. Characters that fail parity are still delivered.
- R9: After lock is dropped, the aligner hunts again and relocks on a fresh run of SYN characters, then delivers data at the new alignment.
- R10: `char_vld_o` and `syn_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Recovered data bit, valid when `bit_stb_i` is high |
| bit_stb_i | input | 1 | One-cycle strobe per received bit |
| char_o | output | CHAR_W | Last aligned character |
| char_vld_o | output | 1 | Pulse: `char_o` holds a data character |
| syn_o | output | 1 | Pulse: a SYN was received while locked |
| par_err_o | output | 1 | Parity failure flag for the character on `char_o` |
| locked_o | output | 1 | Character alignment is established |

## Verification
The bench opens with 13 idle ones, so the first SYN sits at an offset that is not a multiple of 8. A design that only tried byte-aligned windows would never lock. A SYN followed by a null character comes next: an aligner that locked on one match, or that counted matches without requiring them to be consecutive, would raise `locked_o` too early and deliver misaligned data. The parity run is broken once by a good character and once by a SYN, and only the third failure in a row should drop lock. A counter that was not cleared by a SYN, or that was off by one, would unlock at the wrong character. The stream that follows the loss of lock leads into a fresh SYN pair, and it shows whether hunting really restarts and whether the outputs stay silent in between.

// File: rtl/syn_aligner_pkg.sv
package syn_aligner_pkg;
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCKED  = 2'd2
  } align_state_e;
endpackage

// File: rtl/syn_shifter.sv
module syn_shifter #(
  parameter int CHAR_W    = 8,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              bit_i,
  output logic [CHAR_W-1:0] win_nxt_o
);
  logic [CHAR_W-1:0] win_q;

  generate
    if (MSB_FIRST) begin : g_msb
      assign win_nxt_o = {win_q[CHAR_W-2:0], bit_i};
    end else begin : g_lsb
      assign win_nxt_o = {bit_i, win_q[CHAR_W-1:1]};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    win_q <= '0;
    else if (stb_i) win_q <= win_nxt_o;
  end
endmodule

// File: rtl/syn_matcher.sv
module syn_matcher #(
  parameter int                CHAR_W   = 8,
  parameter logic [CHAR_W-1:0] SYN_CODE = 8'h16,
  parameter bit                PAR_ODD  = 1'b1
) (
  input  logic [CHAR_W-1:0] win_i,
  output logic              is_syn_o,
  output logic              par_bad_o
);
  assign is_syn_o = (win_i == SYN_CODE);

  generate
    if (PAR_ODD) begin : g_odd
      assign par_bad_o = ~(^win_i);
    end else begin : g_even
      assign par_bad_o = ^win_i;
    end
  endgenerate
endmodule

// File: rtl/syn_ctrl.sv
module syn_ctrl
  import syn_aligner_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int LOCK_N = 2,
  parameter int BAD_N  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic is_syn_i,
  input  logic par_bad_i,
  output logic done_o,
  output logic locked_o
);
  localparam int CW = $clog2(CHAR_W);
  localparam int MW = $clog2(LOCK_N + 1);
  localparam int BW = $clog2(BAD_N + 1);
  localparam logic [CW-1:0] POS_LAST   = CW'(CHAR_W - 1);
  localparam logic [MW-1:0] MATCH_LAST = MW'(LOCK_N - 1);
  localparam logic [BW-1:0] BAD_LAST   = BW'(BAD_N - 1);

  align_state_e st_q, st_d;
  logic [CW-1:0] pos_q, pos_d, fill_q, fill_d;
  logic [MW-1:0] match_q, match_d;
  logic [BW-1:0] bad_q, bad_d;

  always_comb begin
    st_d    = st_q;
    pos_d   = pos_q;
    fill_d  = fill_q;
    match_d = match_q;
    bad_d   = bad_q;
    done_o  = 1'b0;
    if (stb_i) begin
      unique case (st_q)
        ST_HUNT: begin
          // fill saturates once a full window is present; then every bit is a slip
          if (fill_q != POS_LAST) begin
            fill_d = fill_q + 1'b1;
          end else if (is_syn_i) begin
            pos_d = '0;
            bad_d = '0;
            if (LOCK_N == 1) begin
              st_d = ST_LOCKED;
            end else begin
              st_d    = ST_CONFIRM;
              match_d = MW'(1);
            end
          end
        end
        ST_CONFIRM: begin
          if (pos_q != POS_LAST) begin
            pos_d = pos_q + 1'b1;
          end else begin
            pos_d = '0;
            if (!is_syn_i)                 st_d = ST_HUNT;
            else if (match_q == MATCH_LAST) st_d = ST_LOCKED;
            else                            match_d = match_q + 1'b1;
          end
        end
        ST_LOCKED: begin
          if (pos_q != POS_LAST) begin
            pos_d = pos_q + 1'b1;
          end else begin
            pos_d  = '0;
            done_o = 1'b1;
            if (is_syn_i || !par_bad_i) begin
              bad_d = '0;
            end else if (bad_q == BAD_LAST) begin
              st_d   = ST_HUNT;
              fill_d = POS_LAST;
            end else begin
              bad_d = bad_q + 1'b1;
            end
          end
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_HUNT;
      pos_q   <= '0;
      fill_q  <= '0;
      match_q <= '0;
      bad_q   <= '0;
    end else begin
      st_q    <= st_d;
      pos_q   <= pos_d;
      fill_q  <= fill_d;
      match_q <= match_d;
      bad_q   <= bad_d;
    end
  end

  assign locked_o = (st_q == ST_LOCKED);
endmodule

// File: rtl/syn_aligner.sv
module syn_aligner #(
  parameter int                CHAR_W    = 8,
  parameter logic [CHAR_W-1:0] SYN_CODE  = 8'h16,
  parameter bit                MSB_FIRST = 1'b1,
  parameter bit                PAR_ODD   = 1'b1,
  parameter int                LOCK_N    = 2,
  parameter int                BAD_N     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              bit_stb_i,
  output logic [CHAR_W-1:0] char_o,
  output logic              char_vld_o,
  output logic              syn_o,
  output logic              par_err_o,
  output logic              locked_o
);
  logic [CHAR_W-1:0] win_nxt;
  logic is_syn, par_bad, done;

  syn_shifter #(.CHAR_W(CHAR_W), .MSB_FIRST(MSB_FIRST)) u_shift (
    .clk_i, .rst_ni, .stb_i(bit_stb_i), .bit_i, .win_nxt_o(win_nxt)
  );

  syn_matcher #(.CHAR_W(CHAR_W), .SYN_CODE(SYN_CODE), .PAR_ODD(PAR_ODD)) u_match (
    .win_i(win_nxt), .is_syn_o(is_syn), .par_bad_o(par_bad)
  );

  syn_ctrl #(.CHAR_W(CHAR_W), .LOCK_N(LOCK_N), .BAD_N(BAD_N)) u_ctrl (
    .clk_i, .rst_ni, .stb_i(bit_stb_i), .is_syn_i(is_syn), .par_bad_i(par_bad),
    .done_o(done), .locked_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      char_o     <= '0;
      char_vld_o <= 1'b0;
      syn_o      <= 1'b0;
      par_err_o  <= 1'b0;
    end else begin
      char_vld_o <= done && !is_syn;
      syn_o      <= done && is_syn;
      par_err_o  <= done && !is_syn && par_bad;
      if (done) char_o <= win_nxt;
    end
  end
endmodule

// File: rtl/syn_aligner_chk.sv
module syn_aligner_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_stb_i,
  input logic char_vld_o,
  input logic syn_o,
  input logic par_err_o,
  input logic locked_o
);
  a_r10_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(char_vld_o && syn_o));

  a_r2_quiet_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_vld_o || syn_o) |-> $past(locked_o));

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_vld_o || syn_o) |=> !(char_vld_o || syn_o));

  a_r5_after_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_vld_o || syn_o) |-> $past(bit_stb_i));

  a_r4_lock_on_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(bit_stb_i));

  a_r8_drop_on_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> (char_vld_o && par_err_o));

  a_r7_flag_with_char: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o |-> char_vld_o);
endmodule

bind syn_aligner syn_aligner_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_stb_i(bit_stb_i),
  .char_vld_o(char_vld_o), .syn_o(syn_o), .par_err_o(par_err_o), .locked_o(locked_o)
);

// File: tb/syn_aligner_test.sv
module syn_aligner_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b1;
  logic stb = 1'b0;
  logic [7:0] char_out;
  logic char_vld, syn_out, par_err, locked;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic       is_syn;
    logic [7:0] data;
    logic       perr;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  syn_aligner uut (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_in), .bit_stb_i(stb),
    .char_o(char_out), .char_vld_o(char_vld), .syn_o(syn_out),
    .par_err_o(par_err), .locked_o(locked)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_in = b;
    stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // kind: 0 = no output expected, 1 = SYN flag, 2 = data character
  task automatic send_byte(input logic [7:0] b, input int kind, input string req);
    exp_t e;
    if (kind != 0) begin
      e.is_syn = (kind == 1);
      e.data   = b;
      e.perr   = (kind == 2) && ($countones(b) % 2 == 0);
      e.req    = req;
      exp_q.push_back(e);
    end
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic check_lock(input logic exp, input string req);
    repeat (2) @(negedge clk);
    check(locked == exp, req, "locked_o", locked, exp);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (char_vld || syn_out)) begin
      check(!(char_vld && syn_out), "R10", "both strobes", 1, 0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected output", char_out, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(syn_out == e.is_syn, e.req, "syn_o", syn_out, e.is_syn);
        check(char_vld == !e.is_syn, e.req, "char_vld_o", char_vld, !e.is_syn);
        if (!e.is_syn) begin
          check(char_out == e.data, e.req, "char_o", char_out, e.data);
          check(par_err == e.perr, "R7", "par_err_o", par_err, e.perr);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check({locked, char_vld, syn_out, par_err} == 4'b0, "R1", "reset outputs",
          {locked, char_vld, syn_out, par_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: 13 idle ones put the SYN off byte alignment
    for (int i = 0; i < 13; i++) send_bit(1'b1);
    // R4: single SYN broken by a null does not lock
    send_byte(8'h16, 0, "R4");
    send_byte(8'h00, 0, "R4");
    check_lock(1'b0, "R4");
    send_byte(8'h16, 0, "R4");
    check_lock(1'b0, "R4");
    send_byte(8'h16, 0, "R3");
    check_lock(1'b1, "R3");

    // R5/R6: locked delivery
    send_byte(8'h16, 1, "R6");
    send_byte(8'h07, 2, "R5");
    send_byte(8'h80, 2, "R5");
    send_byte(8'hA7, 2, "R5");

    // R8: parity failure runs
    send_byte(8'h03, 2, "R8");
    send_byte(8'h55, 2, "R8");
    send_byte(8'h01, 2, "R8");
    send_byte(8'h16, 1, "R8");
    send_byte(8'h00, 2, "R8");
    send_byte(8'hFF, 2, "R8");
    check_lock(1'b1, "R8");
    send_byte(8'h33, 2, "R8");
    check_lock(1'b0, "R8");

    // R9: hunting again, silent, then relock
    send_byte(8'h00, 0, "R2");
    send_byte(8'h00, 0, "R2");
    send_byte(8'h16, 0, "R9");
    send_byte(8'h16, 0, "R9");
    check_lock(1'b1, "R9");
    send_byte(8'h0B, 2, "R9");
    send_byte(8'h16, 1, "R9");
    repeat (4) @(negedge clk);

    check(exp_q.size() == 0, "R5", "missing outputs", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule